// File: doc/BRIEF.md
# Programmable LCD Panel Timing Generator

This block produces the line and frame timing for a TFT panel, advancing one step per pixel clock. Software loads a small set of registers through a simple write port: sync pulse widths, the horizontal and vertical totals, the active-area windows and four auxiliary strobe windows. From these the block drives HSYNC, VSYNC, a data-enable window, raw line and frame positions, and pixel and line indices inside the active area. Each auxiliary strobe is placed by a start/end pair inside the line. It serves panels that need extra gate or source control pulses, and it may run past the end of the line into the next one.

Every window register packs its start in bits 31:16 and its end in bits 15:0. Writes land in staging registers, and the running generator copies them only at a frame boundary. A frame in progress therefore never sees half of a new setting. A serial mode sends each pixel as three consecutive clocks, one per colour channel. In that mode the pixel index advances every third clock and a channel index marks the colour. A control register starts the generator, requests a stop at the end of the current frame, or stops it at once.

Top module: `lcd_timing_gen`

## Requirements
- R1: After reset the generator is idle. hsync, vsync, de and every aux output are 0, and h_pos, v_pos, pix_x, pix_y and chan are 0.
- R2: While running, h_pos counts 0 to Htot-1 and then wraps to 0, and v_pos advances at each wrap, counting 0 to Vtot-1. Address 3 holds Htot in bits 31:16 and Vtot in bits 15:0. A start sets both counters to 0 on the clock edge of the start write.
- R3: hsync is (h_pos < HW) XOR control bit 3, and vsync is (v_pos < VW) XOR control bit 4. HW comes from address 1 and VW from address 2, bits 15:0 in both.
- R4: de is 1 exactly when HS <= h_pos < HE and VS <= v_pos < VE. HS/HE come from address 4 and VS/VE from address 5, with the start in bits 31:16 and the end in bits 15:0.
- R5: aux[k] is (AS <= h_pos < AE) XOR control bit 8+k, with AS/AE taken from address 8+k (start in bits 31:16, end in bits 15:0). A window with AS = AE never asserts.
- R6: When AE >= Htot, aux[k] is also asserted for h_pos < AE-Htot, so the strobe carries over into the next line.
- R7: While de is 1, pix_y = v_pos-VS and, outside serial mode, pix_x = h_pos-HS with chan = 0. While de is 0, pix_x, pix_y and chan are 0.
- R8: With control bit 2 set (serial mode), chan steps 0,1,2 over consecutive de clocks, and pix_x = (h_pos-HS)/3.
- R9: Register writes take effect only at the first clock of the next frame. A start from idle uses the staged values together with the control bits of the start write.
- R10: Writing the control register (address 0) with bit 0 = 1 and bit 1 = 1 lets the current frame finish. After the frame the generator is idle, with counters at 0 and every output at its inactive level (the polarity bit).
- R11: Writing the control register with bit 0 = 0 makes the generator idle from the next clock, even in the middle of a line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 32 | Register write data |
| hsync | output | 1 | Line sync, polarity applied |
| vsync | output | 1 | Frame sync, polarity applied |
| de | output | 1 | Active-area data enable |
| aux | output | NAUX | Auxiliary per-line strobes, polarity applied |
| h_pos | output | CW | Clock position within the line |
| v_pos | output | CW | Line position within the frame |
| pix_x | output | CW | Pixel index inside the active area |
| pix_y | output | CW | Line index inside the active area |
| chan | output | 2 | Colour channel index in serial mode |

## Verification
The hardest situation to reach is a reprogramming in the middle of a frame. The old totals, windows, polarities and serial setting must all stay in force until the exact frame boundary, and then switch together. The stimulus writes new totals, a new horizontal window and a new control word partway through a running frame. It then compares every output on every clock against an arithmetic model that holds separate staged and active copies, covering the remainder of the old frame and two frames of the new geometry. The same run also covers a stop requested for the end of the frame, then a restart followed by an immediate stop in the middle of the active area.

// File: rtl/lcd_timing_gen.sv
module lcd_timing_gen #(
  parameter int CW   = 16,
  parameter int NAUX = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [3:0]      wr_addr,
  input  logic [31:0]     wr_data,
  output logic            hsync,
  output logic            vsync,
  output logic            de,
  output logic [NAUX-1:0] aux,
  output logic [CW-1:0]   h_pos,
  output logic [CW-1:0]   v_pos,
  output logic [CW-1:0]   pix_x,
  output logic [CW-1:0]   pix_y,
  output logic [1:0]      chan
);

  localparam logic [3:0] A_CTL = 4'd0, A_HSW = 4'd1, A_VSW = 4'd2,
                         A_TOT = 4'd3, A_HWIN = 4'd4, A_VWIN = 4'd5;

  logic [CW-1:0] hsw_s, vsw_s, htot_s, vtot_s, hws_s, hwe_s, vws_s, vwe_s;
  logic [CW-1:0] hsw_a, vsw_a, htot_a, vtot_a, hws_a, hwe_a, vws_a, vwe_a;
  logic [CW-1:0] axs_s [NAUX];
  logic [CW-1:0] axe_s [NAUX];
  logic [CW-1:0] axs_a [NAUX];
  logic [CW-1:0] axe_a [NAUX];
  logic ser_s, hp_s, vp_s, ser_a, hp_a, vp_a;
  logic [NAUX-1:0] ap_s, ap_a;
  logic act, stop_pend;
  logic [CW-1:0] px;
  logic [1:0] ch;

  wire ctl_wr     = wr_en && wr_addr == A_CTL;
  wire stop_now   = ctl_wr && !wr_data[0];
  wire start      = ctl_wr && wr_data[0] && !act;
  wire h_last     = h_pos == htot_a - 1'b1;
  wire frame_last = act && h_last && v_pos == vtot_a - 1'b1;
  wire load       = start || frame_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {hsw_s, vsw_s, htot_s, vtot_s} <= '0;
      {hws_s, hwe_s, vws_s, vwe_s} <= '0;
      {ser_s, hp_s, vp_s} <= '0;
      ap_s <= '0;
      for (int k = 0; k < NAUX; k++) begin
        axs_s[k] <= '0;
        axe_s[k] <= '0;
      end
    end else if (wr_en) begin
      case (wr_addr)
        A_CTL: begin
          ser_s <= wr_data[2];
          hp_s  <= wr_data[3];
          vp_s  <= wr_data[4];
          ap_s  <= wr_data[8 +: NAUX];
        end
        A_HSW:  hsw_s <= wr_data[0 +: CW];
        A_VSW:  vsw_s <= wr_data[0 +: CW];
        A_TOT:  begin htot_s <= wr_data[16 +: CW]; vtot_s <= wr_data[0 +: CW]; end
        A_HWIN: begin hws_s  <= wr_data[16 +: CW]; hwe_s  <= wr_data[0 +: CW]; end
        A_VWIN: begin vws_s  <= wr_data[16 +: CW]; vwe_s  <= wr_data[0 +: CW]; end
        default: ;
      endcase
      for (int k = 0; k < NAUX; k++)
        if (wr_addr == 4'(8 + k)) begin
          axs_s[k] <= wr_data[16 +: CW];
          axe_s[k] <= wr_data[0 +: CW];
        end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {hsw_a, vsw_a, htot_a, vtot_a} <= '0;
      {hws_a, hwe_a, vws_a, vwe_a} <= '0;
      {ser_a, hp_a, vp_a} <= '0;
      ap_a <= '0;
      for (int k = 0; k < NAUX; k++) begin
        axs_a[k] <= '0;
        axe_a[k] <= '0;
      end
    end else if (load) begin
      {hsw_a, vsw_a, htot_a, vtot_a} <= {hsw_s, vsw_s, htot_s, vtot_s};
      {hws_a, hwe_a, vws_a, vwe_a} <= {hws_s, hwe_s, vws_s, vwe_s};
      ser_a <= start ? wr_data[2] : ser_s;
      hp_a  <= start ? wr_data[3] : hp_s;
      vp_a  <= start ? wr_data[4] : vp_s;
      ap_a  <= start ? wr_data[8 +: NAUX] : ap_s;
      for (int k = 0; k < NAUX; k++) begin
        axs_a[k] <= axs_s[k];
        axe_a[k] <= axe_s[k];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act <= 1'b0;
      stop_pend <= 1'b0;
      h_pos <= '0;
      v_pos <= '0;
    end else if (stop_now || (frame_last && stop_pend)) begin
      act <= 1'b0;
      stop_pend <= 1'b0;
      h_pos <= '0;
      v_pos <= '0;
    end else if (start) begin
      act <= 1'b1;
      stop_pend <= wr_data[1];
      h_pos <= '0;
      v_pos <= '0;
    end else if (act) begin
      if (ctl_wr) stop_pend <= stop_pend | wr_data[1];
      if (h_last) begin
        h_pos <= '0;
        v_pos <= (v_pos == vtot_a - 1'b1) ? '0 : v_pos + 1'b1;
      end else begin
        h_pos <= h_pos + 1'b1;
      end
    end
  end

  wire de_raw = act && h_pos >= hws_a && h_pos < hwe_a && v_pos >= vws_a && v_pos < vwe_a;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      px <= '0;
      ch <= '0;
    end else if (stop_now || start || !de_raw || h_last) begin
      px <= '0;
      ch <= '0;
    end else if (!ser_a) begin
      px <= px + 1'b1;
    end else if (ch == 2'd2) begin
      ch <= '0;
      px <= px + 1'b1;
    end else begin
      ch <= ch + 1'b1;
    end
  end

  assign hsync = (act && h_pos < hsw_a) ^ hp_a;
  assign vsync = (act && v_pos < vsw_a) ^ vp_a;
  assign de    = de_raw;
  assign pix_x = de_raw ? px : '0;
  assign chan  = de_raw ? ch : '0;
  assign pix_y = de_raw ? v_pos - vws_a : '0;

  for (genvar k = 0; k < NAUX; k++) begin : g_aux
    wire body = h_pos >= axs_a[k] && h_pos < axe_a[k];
    wire tail = axe_a[k] >= htot_a && h_pos < axe_a[k] - htot_a;
    assign aux[k] = (act && (body || tail)) ^ ap_a[k];
  end

endmodule

module lcd_timing_gen_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [3:0]    wr_addr,
  input logic [31:0]   wr_data,
  input logic          act,
  input logic          frame_last,
  input logic [CW-1:0] htot_a,
  input logic [CW-1:0] vtot_a,
  input logic          ser_a,
  input logic [CW-1:0] h_pos,
  input logic [CW-1:0] v_pos,
  input logic          de,
  input logic [CW-1:0] pix_x,
  input logic [1:0]    chan
);

  // R2
  hwrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act && h_pos == htot_a - 1'b1 |=> h_pos == '0);

  // R2
  vbound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act && vtot_a != '0 |-> v_pos < vtot_a);

  // R9
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act && !frame_last |=> $stable(htot_a) && $stable(vtot_a));

  // R7
  pix_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(de) |-> pix_x == '0 && chan == 2'd0);

  // R8
  ser_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    de && $past(de) && ser_a && h_pos != '0 && $past(chan) != 2'd2 |-> pix_x == $past(pix_x));

  // R8
  chan_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chan != 2'd3);

  // R11
  quick_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_addr == 4'd0 && !wr_data[0] |=> !act && h_pos == '0 && v_pos == '0 && !de);

endmodule

bind lcd_timing_gen lcd_timing_gen_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .act(act), .frame_last(frame_last), .htot_a(htot_a), .vtot_a(vtot_a),
  .ser_a(ser_a), .h_pos(h_pos), .v_pos(v_pos), .de(de), .pix_x(pix_x), .chan(chan)
);

// File: tb/lcd_timing_gen_bench.sv
module lcd_timing_gen_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic hsync, vsync, de;
  logic [3:0] aux;
  logic [15:0] h_pos, v_pos, pix_x, pix_y;
  logic [1:0] chan;

  int checks = 0, errors = 0;
  bit done = 0;

  lcd_timing_gen u_lcd_timing_gen (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .hsync(hsync), .vsync(vsync), .de(de), .aux(aux), .h_pos(h_pos), .v_pos(v_pos),
    .pix_x(pix_x), .pix_y(pix_y), .chan(chan)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // model: staged (s_) and active (c_) copies
  int s_ctl, s_hsw, s_vsw, s_ht, s_vt, s_hws, s_hwe, s_vws, s_vwe;
  int c_ctl, c_hsw, c_vsw, c_ht, c_vt, c_hws, c_hwe, c_vws, c_vwe;
  int s_as[4], s_ae[4], c_as[4], c_ae[4];
  int eh = 0, ev = 0;
  bit m_act = 0, m_sp = 0;

  initial begin
    {s_ctl, s_hsw, s_vsw, s_ht, s_vt, s_hws, s_hwe, s_vws, s_vwe} = '0;
    {c_ctl, c_hsw, c_vsw, c_ht, c_vt, c_hws, c_hwe, c_vws, c_vwe} = '0;
    for (int k = 0; k < 4; k++) begin s_as[k] = 0; s_ae[k] = 0; c_as[k] = 0; c_ae[k] = 0; end
  end

  task automatic chk(string tag, int act_v, int exp_v);
    checks++;
    if (act_v != exp_v) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d (h=%0d v=%0d t=%0t)", tag, act_v, exp_v, eh, ev, $time);
    end
  endtask

  task automatic load_cur();
    c_ctl = s_ctl; c_hsw = s_hsw; c_vsw = s_vsw; c_ht = s_ht; c_vt = s_vt;
    c_hws = s_hws; c_hwe = s_hwe; c_vws = s_vws; c_vwe = s_vwe;
    for (int k = 0; k < 4; k++) begin c_as[k] = s_as[k]; c_ae[k] = s_ae[k]; end
  endtask

  task automatic check_outputs();
    bit ser, e_de;
    int off;
    ser  = ((c_ctl >> 2) & 1) != 0;
    e_de = m_act && eh >= c_hws && eh < c_hwe && ev >= c_vws && ev < c_vwe;
    off  = eh - c_hws;
    chk("R2 h_pos", h_pos, eh);
    chk("R2 v_pos", v_pos, ev);
    chk("R3 hsync", hsync, int'(m_act && eh < c_hsw) ^ ((c_ctl >> 3) & 1));
    chk("R3 vsync", vsync, int'(m_act && ev < c_vsw) ^ ((c_ctl >> 4) & 1));
    chk("R4 de", de, int'(e_de));
    chk("R7 pix_y", pix_y, e_de ? ev - c_vws : 0);
    chk(ser ? "R8 pix_x" : "R7 pix_x", pix_x, e_de ? (ser ? off / 3 : off) : 0);
    chk("R8 chan", chan, (e_de && ser) ? off % 3 : 0);
    for (int k = 0; k < 4; k++) begin
      bit body, tail;
      body = eh >= c_as[k] && eh < c_ae[k];
      tail = c_ae[k] >= c_ht && eh < c_ae[k] - c_ht;
      chk(tail ? "R6 aux" : "R5 aux", aux[k], int'(m_act && (body || tail)) ^ ((c_ctl >> (8 + k)) & 1));
    end
  endtask

  task automatic advance(bit we, int a, int d);
    bit was, last;
    was  = m_act;
    last = m_act && eh == c_ht - 1 && ev == c_vt - 1;
    if (m_act) begin
      if (eh == c_ht - 1) begin eh = 0; ev = (ev == c_vt - 1) ? 0 : ev + 1; end
      else eh++;
    end
    if (last) begin
      load_cur();
      if (m_sp) begin m_act = 0; eh = 0; ev = 0; m_sp = 0; end
    end
    if (we) begin
      case (a)
        0: s_ctl = d;
        1: s_hsw = d & 16'hFFFF;
        2: s_vsw = d & 16'hFFFF;
        3: begin s_ht = (d >> 16) & 16'hFFFF; s_vt = d & 16'hFFFF; end
        4: begin s_hws = (d >> 16) & 16'hFFFF; s_hwe = d & 16'hFFFF; end
        5: begin s_vws = (d >> 16) & 16'hFFFF; s_vwe = d & 16'hFFFF; end
        8, 9, 10, 11: begin s_as[a-8] = (d >> 16) & 16'hFFFF; s_ae[a-8] = d & 16'hFFFF; end
        default: ;
      endcase
      if (a == 0) begin
        if ((d & 1) == 0) begin m_act = 0; eh = 0; ev = 0; m_sp = 0; end
        else if (!was) begin load_cur(); m_act = 1; eh = 0; ev = 0; m_sp = ((d >> 1) & 1) != 0; end
        else m_sp = m_sp | (((d >> 1) & 1) != 0);
      end
    end
  endtask

  task automatic step();
    check_outputs();
    @(negedge clk);
    advance(wr_en, int'(wr_addr), int'(wr_data));
  endtask

  task automatic steps(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic wr(int a, int d);
    wr_en = 1'b1; wr_addr = 4'(a); wr_data = 32'(d);
    step();
    wr_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 hsync", hsync, 0); chk("R1 vsync", vsync, 0); chk("R1 de", de, 0);
    chk("R1 aux", aux, 0); chk("R1 h_pos", h_pos, 0); chk("R1 v_pos", v_pos, 0);
    chk("R1 pix_x", pix_x, 0); chk("R1 pix_y", pix_y, 0); chk("R1 chan", chan, 0);
    steps(3);
    // program first geometry: 10x6 frame, window 3..8 x 2..5
    wr(1, 2); wr(2, 1); wr(3, 32'h000A_0006);
    wr(4, 32'h0003_0008); wr(5, 32'h0002_0005);
    wr(8, 32'h0001_0004); wr(9, 32'h0007_000D);
    wr(10, 32'h0000_000A); wr(11, 32'h0005_0005);
    steps(4);
    // R9 start: hsync and aux1 inverted
    wr(0, 32'h209);
    steps(120);
    // R9 mid-frame reprogramming, serial mode, vsync inverted
    steps(15);
    wr(3, 32'h000C_0007);
    wr(4, 32'h0003_0009);
    wr(0, 32'h15);
    steps(230);
    // R10 stop at end of frame
    wr(0, 32'h17);
    steps(120);
    // R11 restart in plain mode, then stop inside the active area
    wr(0, 32'h01);
    steps(30);
    wr(0, 32'h00);
    steps(12);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule